// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block sits beside a CPU bus and compares every presented bus cycle against two programmed breakpoint channels, A and B. Each channel holds a target address with a don't-care mask, a cycle condition (instruction fetch or data access, read or write, optionally a fixed operand size) and an optional address-space identifier check. Channel B adds a data-value comparison, also under a don't-care mask. When a cycle satisfies a channel, the block raises a one-cycle break request for the exception logic and sets that channel's sticky match flag.

The channels work in one of two modes. In independent mode either channel alone causes a break. In sequence mode a channel A hit only arms the block, and the break comes on a later channel B hit. Conditions that can never occur on a real bus (a fetch that writes, a fetch from an odd address) are rejected outright, so they never fire.

Software programs the block through a simple write port: a select code picks one of nine registers and a 32-bit word carries the value.

Top module: `bkpt_unit`

## Requirements
- R1: A channel matches only when its enable bit (condition bit 0) is set, `busValid` is high and the bus address equals the programmed address in every bit whose address-mask bit is 0; with a mask of zero the whole address must be equal. Register selects: 0 A address, 1 A address mask, 2 A condition, 3 B address, 4 B address mask, 5 B condition, 6 B data, 7 B data mask, 8 control.
- R2: An address-mask bit of 1 removes that address bit from the comparison.
- R3: When condition bit 6 is set, the channel also requires `busAsid` to equal condition bits 15:8; when bit 6 is clear the identifier is ignored.
- R4: Condition bit 1 selects fetch (1) or data (0) and must equal `busFetch`; bit 2 selects write (1) or read (0) and must equal `busWrite`; when bit 3 is set, bits 5:4 must equal `busSize` (0 byte, 1 word, 2 long), and when bit 3 is clear the size is ignored.
- R5: On data cycles channel B also requires `busData` to equal the B data register in every bit whose data-mask bit is 0; on fetch cycles the data is not compared. Channel A never compares data.
- R6: A channel programmed for fetch with write direction never matches.
- R7: A channel programmed for fetch whose address bit 0 is 1 and unmasked never matches.
- R8: With control bit 0 clear (independent mode), a hit on either channel asserts `brkReq` one clock after the cycle.
- R9: With control bit 0 set (sequence mode), a channel A hit only arms; `brkReq` asserts one clock after a channel B hit seen while armed, and a B hit with the block not armed gives no break.
- R10: The armed state clears when a sequence break fires and on any register write.
- R11: `matchA`/`matchB` set one clock after their channel hits and stay set until a control write with bit 1 (A) or bit 2 (B) equal to 0; a 1 in those bits leaves the flag unchanged, and a hit in the same cycle wins.
- R12: `brkReq` is a one-cycle pulse per qualifying valid cycle; a cycle with `busValid` low never causes a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus cycle present |
| busAddr | input | ADDR_W | Bus address |
| busData | input | DATA_W | Bus data |
| busAsid | input | ASID_W | Address-space identifier of the cycle |
| busFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0 byte, 1 word, 2 long |
| regWe | input | 1 | Register write strobe |
| regSel | input | 4 | Register select |
| regWdata | input | REG_W | Register write value |
| brkReq | output | 1 | Break request pulse |
| matchA | output | 1 | Sticky channel A match flag |
| matchB | output | 1 | Sticky channel B match flag |

## Verification
The assertions check every cycle that independent-mode hits always become a break, that no break follows a cycle without a hit, that a sequence break is always preceded by an armed B hit and leaves the block disarmed, that no fetch-type hit ever happens on a write, and that a match flag only drops on a clearing control write. The address and data masking, identifier qualification, size handling, the odd-address fetch rule and the disarming on register writes are shown only by the bench's directed scenarios, which compute the expected break and flags from the programmed values.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] SEL_ADDR_A  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_AMASK_A = 4'd1;
  localparam logic [SEL_W-1:0] SEL_COND_A  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_ADDR_B  = 4'd3;
  localparam logic [SEL_W-1:0] SEL_AMASK_B = 4'd4;
  localparam logic [SEL_W-1:0] SEL_COND_B  = 4'd5;
  localparam logic [SEL_W-1:0] SEL_DATA_B  = 4'd6;
  localparam logic [SEL_W-1:0] SEL_DMASK_B = 4'd7;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 4'd8;

  // load strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] ldAddr;
    logic [NUM_CH-1:0] ldMask;
    logic [NUM_CH-1:0] ldCond;
    logic              ldData;
    logic              ldDataMask;
  } dpStrobe_t;
endpackage

// File: rtl/bkpt_chan.sv
module bkpt_chan #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ASID_W   = 8,
  parameter int REG_W    = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldAddr,
  input  logic              ldMask,
  input  logic              ldCond,
  input  logic              ldData,
  input  logic              ldDataMask,
  input  logic [REG_W-1:0]  wData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [ASID_W-1:0] busAsid,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  output logic              hit
);
  localparam int ASID_LSB = 8;

  logic [ADDR_W-1:0] addrQ, maskQ;
  logic [DATA_W-1:0] dataQ, dmaskQ;
  logic              enQ, fetchQ, writeQ, sizeChkQ, asidEnQ;
  logic [1:0]        sizeQ;
  logic [ASID_W-1:0] asidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      maskQ    <= '0;
      enQ      <= 1'b0;
      fetchQ   <= 1'b0;
      writeQ   <= 1'b0;
      sizeChkQ <= 1'b0;
      sizeQ    <= '0;
      asidEnQ  <= 1'b0;
      asidQ    <= '0;
    end else begin
      if (ldAddr) addrQ <= wData[ADDR_W-1:0];
      if (ldMask) maskQ <= wData[ADDR_W-1:0];
      if (ldCond) begin
        enQ      <= wData[0];
        fetchQ   <= wData[1];
        writeQ   <= wData[2];
        sizeChkQ <= wData[3];
        sizeQ    <= wData[5:4];
        asidEnQ  <= wData[6];
        asidQ    <= wData[ASID_LSB +: ASID_W];
      end
    end
  end

  logic dataOk;
  generate
    if (HAS_DATA) begin : g_data
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataQ  <= '0;
          dmaskQ <= '0;
        end else begin
          if (ldData)     dataQ  <= wData[DATA_W-1:0];
          if (ldDataMask) dmaskQ <= wData[DATA_W-1:0];
        end
      end
      // data is only meaningful on data cycles
      assign dataOk = busFetch | (((busData ^ dataQ) & ~dmaskQ) == '0);
    end else begin : g_nodata
      assign dataQ  = '0;
      assign dmaskQ = '0;
      assign dataOk = 1'b1 | ldData | ldDataMask;
    end
  endgenerate

  logic addrOk, asidOk, typeOk, sizeOk, impossible;
  always_comb begin
    addrOk     = ((busAddr ^ addrQ) & ~maskQ) == '0;
    asidOk     = !asidEnQ || (busAsid == asidQ);
    typeOk     = (busFetch == fetchQ) && (busWrite == writeQ);
    sizeOk     = !sizeChkQ || (busSize == sizeQ);
    impossible = fetchQ && (writeQ || (addrQ[0] && !maskQ[0]));
    hit = busValid && enQ && !impossible && addrOk && asidOk && typeOk && sizeOk && dataOk;
  end
endmodule

// File: rtl/bkpt_dpath.sv
module bkpt_dpath
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [REG_W-1:0]  wData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [ASID_W-1:0] busAsid,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  output logic [NUM_CH-1:0] hit
);
  localparam int LAST_CH = NUM_CH - 1;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam bit HAS_D = (i == LAST_CH);
      bkpt_chan #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W),
        .REG_W(REG_W), .HAS_DATA(HAS_D)
      ) u_chan (
        .clk       (clk),
        .rstN      (rstN),
        .ldAddr    (stb.ldAddr[i]),
        .ldMask    (stb.ldMask[i]),
        .ldCond    (stb.ldCond[i]),
        .ldData    (HAS_D ? stb.ldData : 1'b0),
        .ldDataMask(HAS_D ? stb.ldDataMask : 1'b0),
        .wData     (wData),
        .busValid  (busValid),
        .busAddr   (busAddr),
        .busData   (busData),
        .busAsid   (busAsid),
        .busFetch  (busFetch),
        .busWrite  (busWrite),
        .busSize   (busSize),
        .hit       (hit[i])
      );
    end
  endgenerate
endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [SEL_W-1:0] regSel,
  input  logic [2:0]       ctrlBits,
  input  logic             hitA,
  input  logic             hitB,
  output dpStrobe_t        stb,
  output logic             brkReq,
  output logic             matchA,
  output logic             matchB,
  output logic             armed,
  output logic             seqMode
);
  logic ctrlWr, fire;

  always_comb begin
    stb = '0;
    if (regWe) begin
      unique case (regSel)
        SEL_ADDR_A:  stb.ldAddr[0]  = 1'b1;
        SEL_AMASK_A: stb.ldMask[0]  = 1'b1;
        SEL_COND_A:  stb.ldCond[0]  = 1'b1;
        SEL_ADDR_B:  stb.ldAddr[1]  = 1'b1;
        SEL_AMASK_B: stb.ldMask[1]  = 1'b1;
        SEL_COND_B:  stb.ldCond[1]  = 1'b1;
        SEL_DATA_B:  stb.ldData     = 1'b1;
        SEL_DMASK_B: stb.ldDataMask = 1'b1;
        default: ;
      endcase
    end
    ctrlWr = regWe && (regSel == SEL_CTRL);
    fire   = seqMode ? (hitB && armed) : (hitA || hitB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brkReq  <= 1'b0;
      matchA  <= 1'b0;
      matchB  <= 1'b0;
      armed   <= 1'b0;
      seqMode <= 1'b0;
    end else begin
      brkReq <= fire;
      if (ctrlWr) seqMode <= ctrlBits[0];
      if (regWe || (seqMode && fire)) armed <= 1'b0;
      else if (seqMode && hitA)        armed <= 1'b1;
      if (hitA) matchA <= 1'b1;
      else if (ctrlWr && !ctrlBits[1]) matchA <= 1'b0;
      if (hitB) matchB <= 1'b1;
      else if (ctrlWr && !ctrlBits[2]) matchB <= 1'b0;
    end
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [ASID_W-1:0] busAsid,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic              regWe,
  input  logic [3:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  output logic              brkReq,
  output logic              matchA,
  output logic              matchB
);
  dpStrobe_t         stb;
  logic [NUM_CH-1:0] hit;
  logic              hitA, hitB, armed, seqMode;

  assign hitA = hit[0];
  assign hitB = hit[1];

  bkpt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .ctrlBits(regWdata[2:0]), .hitA(hitA), .hitB(hitB), .stb(stb),
    .brkReq(brkReq), .matchA(matchA), .matchB(matchB),
    .armed(armed), .seqMode(seqMode)
  );

  bkpt_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wData(regWdata),
    .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busAsid(busAsid), .busFetch(busFetch), .busWrite(busWrite),
    .busSize(busSize), .hit(hit)
  );
endmodule

// File: rtl/bkpt_checker.sv
module bkpt_checker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busFetch,
  input logic             busWrite,
  input logic             regWe,
  input logic [3:0]       regSel,
  input logic [REG_W-1:0] regWdata,
  input logic             brkReq,
  input logic             matchA,
  input logic             matchB,
  input logic             hitA,
  input logic             hitB,
  input logic             armed,
  input logic             seqMode
);
  a_r8_indep_break: assert property (@(posedge clk) disable iff (!rstN)
    (!seqMode && (hitA || hitB)) |=> brkReq);

  a_r12_no_hit_no_break: assert property (@(posedge clk) disable iff (!rstN)
    (!hitA && !hitB) |=> !brkReq);

  a_r12_valid_needed: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (!hitA && !hitB));

  a_r9_seq_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode && hitB && !armed) |=> !brkReq);

  a_r10_disarm_on_break: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode && hitB && armed) |=> (brkReq && !armed));

  a_r10_disarm_on_write: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !armed);

  a_r6_fetch_never_writes: assert property (@(posedge clk) disable iff (!rstN)
    ((hitA || hitB) && busFetch) |-> !busWrite);

  a_r11_flag_a_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (matchA && !(regWe && regSel == 4'd8 && !regWdata[1])) |=> matchA);

  a_r11_flag_b_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (matchB && !(regWe && regSel == 4'd8 && !regWdata[2])) |=> matchB);
endmodule

bind bkpt_unit bkpt_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busFetch(busFetch),
  .busWrite(busWrite), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
  .brkReq(brkReq), .matchA(matchA), .matchB(matchB), .hitA(hitA),
  .hitB(hitB), .armed(armed), .seqMode(seqMode)
);

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busData = '0;
  logic [7:0]  busAsid = '0;
  logic        busFetch = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = '0;
  logic        regWe = 1'b0;
  logic [3:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        brkReq, matchA, matchB;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bkpt_unit u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .busAsid(busAsid), .busFetch(busFetch),
    .busWrite(busWrite), .busSize(busSize), .regWe(regWe),
    .regSel(regSel), .regWdata(regWdata), .brkReq(brkReq),
    .matchA(matchA), .matchB(matchB)
  );

  // condition word: en[0] fetch[1] write[2] sizeChk[3] size[5:4] asidEn[6] asid[15:8]
  function automatic logic [31:0] cond(bit en, bit fe, bit wr, bit sc,
                                       logic [1:0] sz, bit ae, logic [7:0] as);
    return {16'h0, as, 1'b0, ae, sz, sc, wr, fe, en};
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [3:0] sel, logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // one bus cycle, returns the break request sampled one clock later
  task automatic busCyc(bit fe, bit wr, logic [1:0] sz, logic [31:0] ad,
                        logic [31:0] da, logic [7:0] as, output logic brk,
                        input bit vld = 1'b1);
    @(negedge clk);
    busValid = vld; busFetch = fe; busWrite = wr; busSize = sz;
    busAddr = ad; busData = da; busAsid = as;
    @(negedge clk);
    busValid = 1'b0;
    brk = brkReq;
  endtask

  task automatic disableAll();
    wrReg(4'd2, 32'h0);
    wrReg(4'd5, 32'h0);
    wrReg(4'd8, 32'h0);
  endtask

  task automatic tReset();
    chk("R12 reset brkReq", brkReq, 1'b0);
    chk("R11 reset matchA", matchA, 1'b0);
    chk("R11 reset matchB", matchB, 1'b0);
  endtask

  task automatic tExact();
    logic b;
    disableAll();
    wrReg(4'd0, 32'h0000_1000);
    wrReg(4'd1, 32'h0);
    wrReg(4'd2, cond(1, 1, 0, 1, 2'd1, 0, 8'h0));
    busCyc(1, 0, 2'd1, 32'h1000, 32'h0, 8'h0, b);
    chk("R1 exact match breaks", b, 1'b1);
    chk("R11 matchA set", matchA, 1'b1);
    @(negedge clk);
    chk("R12 single pulse", brkReq, 1'b0);
    busCyc(1, 0, 2'd1, 32'h1002, 32'h0, 8'h0, b);
    chk("R1 address mismatch", b, 1'b0);
    busCyc(1, 0, 2'd1, 32'h1000, 32'h0, 8'h0, b, 1'b0);
    chk("R12 no valid no break", b, 1'b0);
  endtask

  task automatic tMask();
    logic b;
    wrReg(4'd1, 32'h0000_00F0);
    busCyc(1, 0, 2'd1, 32'h10A0, 32'h0, 8'h0, b);
    chk("R2 masked bits ignored", b, 1'b1);
    busCyc(1, 0, 2'd1, 32'h1100, 32'h0, 8'h0, b);
    chk("R2 unmasked bit compared", b, 1'b0);
    wrReg(4'd1, 32'h0);
  endtask

  task automatic tAsid();
    logic b;
    wrReg(4'd2, cond(1, 1, 0, 1, 2'd1, 1, 8'h80));
    busCyc(1, 0, 2'd1, 32'h1000, 32'h0, 8'h70, b);
    chk("R3 asid mismatch", b, 1'b0);
    busCyc(1, 0, 2'd1, 32'h1000, 32'h0, 8'h80, b);
    chk("R3 asid match", b, 1'b1);
    wrReg(4'd2, cond(1, 1, 0, 1, 2'd1, 0, 8'h80));
    busCyc(1, 0, 2'd1, 32'h1000, 32'h0, 8'h33, b);
    chk("R3 asid ignored when off", b, 1'b1);
  endtask

  task automatic tCycle();
    logic b;
    wrReg(4'd2, cond(1, 0, 1, 1, 2'd1, 0, 8'h0));
    busCyc(0, 1, 2'd1, 32'h1000, 32'h0, 8'h0, b);
    chk("R4 data write word match", b, 1'b1);
    busCyc(0, 0, 2'd1, 32'h1000, 32'h0, 8'h0, b);
    chk("R4 direction mismatch", b, 1'b0);
    busCyc(0, 1, 2'd2, 32'h1000, 32'h0, 8'h0, b);
    chk("R4 size mismatch", b, 1'b0);
    busCyc(1, 1, 2'd1, 32'h1000, 32'h0, 8'h0, b);
    chk("R4 type mismatch", b, 1'b0);
    wrReg(4'd2, cond(1, 0, 1, 0, 2'd1, 0, 8'h0));
    busCyc(0, 1, 2'd2, 32'h1000, 32'h0, 8'h0, b);
    chk("R4 size left out", b, 1'b1);
  endtask

  task automatic tData();
    logic b;
    disableAll();
    wrReg(4'd3, 32'h0000_2000);
    wrReg(4'd4, 32'h0);
    wrReg(4'd6, 32'h1234_5678);
    wrReg(4'd7, 32'h0000_00FF);
    wrReg(4'd5, cond(1, 0, 0, 0, 2'd0, 0, 8'h0));
    busCyc(0, 0, 2'd2, 32'h2000, 32'h1234_56AA, 8'h0, b);
    chk("R5 masked data match", b, 1'b1);
    chk("R11 matchB set", matchB, 1'b1);
    busCyc(0, 0, 2'd2, 32'h2000, 32'h1234_0078, 8'h0, b);
    chk("R5 data mismatch", b, 1'b0);
    wrReg(4'd5, cond(1, 1, 0, 0, 2'd0, 0, 8'h0));
    busCyc(1, 0, 2'd1, 32'h2000, 32'hDEAD_BEEF, 8'h0, b);
    chk("R5 data ignored on fetch", b, 1'b1);
    wrReg(4'd5, 32'h0);
    wrReg(4'd0, 32'h0000_2000);
    wrReg(4'd2, cond(1, 0, 0, 0, 2'd0, 0, 8'h0));
    busCyc(0, 0, 2'd2, 32'h2000, 32'hDEAD_BEEF, 8'h0, b);
    chk("R5 channel A has no data check", b, 1'b1);
  endtask

  task automatic tImpossible();
    logic b;
    disableAll();
    wrReg(4'd0, 32'h0000_3000);
    wrReg(4'd2, cond(1, 1, 1, 0, 2'd0, 0, 8'h0));
    busCyc(1, 1, 2'd1, 32'h3000, 32'h0, 8'h0, b);
    chk("R6 fetch write never", b, 1'b0);
    wrReg(4'd0, 32'h0000_3001);
    wrReg(4'd2, cond(1, 1, 0, 0, 2'd0, 0, 8'h0));
    busCyc(1, 0, 2'd1, 32'h3001, 32'h0, 8'h0, b);
    chk("R7 odd fetch never", b, 1'b0);
    wrReg(4'd2, cond(1, 0, 0, 0, 2'd0, 0, 8'h0));
    busCyc(0, 0, 2'd0, 32'h3001, 32'h0, 8'h0, b);
    chk("R7 odd data address still matches", b, 1'b1);
  endtask

  task automatic tSeq();
    logic b;
    disableAll();
    wrReg(4'd0, 32'h0000_0100);
    wrReg(4'd3, 32'h0000_0200);
    wrReg(4'd4, 32'h0);
    wrReg(4'd7, 32'h0);
    wrReg(4'd2, cond(1, 1, 0, 1, 2'd1, 1, 8'h80));
    wrReg(4'd5, cond(1, 1, 0, 1, 2'd1, 1, 8'h70));
    wrReg(4'd8, 32'h1);
    busCyc(1, 0, 2'd1, 32'h0200, 32'h0, 8'h70, b);
    chk("R9 B before A no break", b, 1'b0);
    busCyc(1, 0, 2'd1, 32'h0100, 32'h0, 8'h80, b);
    chk("R9 A only arms", b, 1'b0);
    busCyc(1, 0, 2'd1, 32'h0200, 32'h0, 8'h70, b);
    chk("R9 B after A breaks", b, 1'b1);
    busCyc(1, 0, 2'd1, 32'h0200, 32'h0, 8'h70, b);
    chk("R10 disarmed after break", b, 1'b0);
    busCyc(1, 0, 2'd1, 32'h0100, 32'h0, 8'h80, b);
    wrReg(4'd3, 32'h0000_0200);
    busCyc(1, 0, 2'd1, 32'h0200, 32'h0, 8'h70, b);
    chk("R10 disarmed by register write", b, 1'b0);
  endtask

  task automatic tFlags();
    @(negedge clk);
    chk("R11 matchA holds", matchA, 1'b1);
    chk("R11 matchB holds", matchB, 1'b1);
    wrReg(4'd8, 32'h4);
    chk("R11 matchA cleared by zero", matchA, 1'b0);
    chk("R11 matchB kept by one", matchB, 1'b1);
    wrReg(4'd8, 32'h2);
    chk("R11 matchB cleared by zero", matchB, 1'b0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExact();
    tMask();
    tAsid();
    tCycle();
    tData();
    tImpossible();
    tSeq();
    tFlags();
    finishRun();
  end
endmodule